// File: doc/BRIEF.md
# Coprocessor Timer and Interrupt-Mask Unit

This block is the timer and interrupt-gating slice of a processor control coprocessor. It holds four registers behind a small register-select bus: a free-running cycle counter, a compare value, a status word, and a pending-interrupt view. When the counter reaches the compare value, the block latches a timer pending flag. That flag stays set until software writes the compare register, whatever value it writes.

The timer flag, five hardware interrupt lines and two software interrupt flags make up an 8-bit pending vector. The unit ANDs this vector with the 8-bit mask in the status word. It then applies the global enable and the two exception-level bits to produce one interrupt request to the core. The request is combinational from the registered state. A source that is already pending therefore raises the request in the same cycle as the write that unmasks or enables it. Hardware lines 4 and 3 are not wired in this configuration, so their pending bits always read zero.

Register select codes are 0 for the counter, 1 for compare, 2 for status and 3 for the pending view. Writes take effect on the clock edge. Reads are combinational from `reg_sel`.

Top module: `cop_timer_intc`

## Requirements
- R1: The counter (select 0) adds one on each clock edge with `tick_en` high and wraps from 0xFFFFFFFF to 0. A write to select 0 loads `wr_data` and takes priority over the increment.
- R2: The clock edge after the counter equals compare sets the timer pending flag (pending bit 7). The flag then stays set until compare is written.
- R3: Any write to compare (select 1) clears the timer pending flag, whatever the value. If the write and a match fall in the same cycle, the flag ends cleared.
- R4: Compare changes only when written, and reads back the last value written.
- R5: Status (select 2) is laid out as IE bit 0, EXL bit 1, ERL bit 2, KSU bits 4:3, UX bit 5, SX bit 6, KX bit 7, mask bits 15:8, diagnostic bits 24:16 and coprocessor-usable bit 28. These bits read back as written. Bits 31:29, 27:26 and 25 read zero.
- R6: Bit 25 of status (the endian-reverse bit) always reads 0, and writes to it are ignored.
- R7: The pending view (select 3) puts the timer flag in bit 7, hardware line n in bit n+2, and the software flags in bits 1:0. Bits 31:8 read zero. A write to select 3 loads bits 1:0 from `wr_data[1:0]` and changes nothing else.
- R8: Hardware lines 4 and 3 (pending bits 6 and 5) always read 0. With only mask bits 14:13 set, they never raise the request.
- R9: `irq_req` is high exactly when some pending bit i has mask bit 8+i set, IE is 1, EXL is 0 and ERL is 0. It reacts in the same cycle as a change in mask or enable.
- R10: After reset, the counter is 0, status is 0x00000004 (only ERL set), the pending view is 0 and `irq_req` is 0. Compare has an arbitrary reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter increment enable |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 counter, 1 compare, 2 status, 3 pending) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register |
| hw_irq | input | 5 | Hardware interrupt lines 4..0, active high |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench puts a compare write in the same cycle as a live match. A design that let the match win would show bit 7 set on the very next read. It also latches a timer flag while the mask is clear and then sets the mask. A design that registered the request, or only looked at new events, would leave `irq_req` low or raise it late. Other cases drive every hardware line high with only the dead lines unmasked, write all ones to status, and wrap the counter. Each of these targets a design that leaks the dead lines, keeps the endian bit writable, or stalls at the top count.

// File: rtl/cop_timer_pkg.sv
// Package: shared widths, register select codes and status field positions
// for the coprocessor timer and interrupt-mask unit.
package cop_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int SEL_W    = 2;
    localparam int IM_W     = 8;
    localparam int HW_N     = 5;
    localparam int SW_N     = 2;

    // Register select codes on the register bus.
    typedef enum logic [SEL_W-1:0] {
        SEL_COUNT  = 2'd0,
        SEL_CMP    = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_PEND   = 2'd3
    } reg_sel_e;

    // Status field positions.
    localparam int ST_IE    = 0;
    localparam int ST_EXL   = 1;
    localparam int ST_ERL   = 2;
    localparam int ST_IM_LO = 8;
    localparam int ST_RE    = 25;

    // Bits of status that hold state: 7:0, 15:8, 24:16 and 28.
    localparam logic [DATA_W-1:0] STATUS_WMASK = 32'h11FF_FFFF;
    localparam logic [DATA_W-1:0] STATUS_RST   = 32'h0000_0004;

    // Pending vector positions.
    localparam int PEND_TMR = 7;
    localparam int PEND_HW  = 2;

endpackage

// File: rtl/cop_count_cmp.sv
// Module: cop_count_cmp
// Holds the free-running counter, the compare register and the sticky
// timer pending flag. Assumes the write strobes are mutually exclusive.
// A compare write always clears the flag, even in a cycle with a match.
module cop_count_cmp #(
    parameter int                 W       = 32,
    parameter logic [W-1:0]       CMP_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         cnt_we,
    input  logic         cmp_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_q,
    output logic [W-1:0] cmp_q,
    output logic         tmr_pend
);

    logic match;

    // Equality of counter and compare in the current cycle.
    assign match = (count_q == cmp_q);

    // Counter: a direct write takes priority over the tick increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_we) begin
            count_q <= wdata;
        end else if (tick_en) begin
            count_q <= count_q + W'(1);
        end
    end

    // Compare: changes only when written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= CMP_RST;
        end else if (cmp_we) begin
            cmp_q <= wdata;
        end
    end

    // Timer pending flag: set on a match, cleared by any compare write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_pend <= 1'b0;
        end else if (cmp_we) begin
            tmr_pend <= 1'b0;
        end else if (match) begin
            tmr_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/cop_status_reg.sv
// Module: cop_status_reg
// Status word. Only the bits in WMASK hold state. All other bits,
// including the endian-reverse bit, read zero and ignore writes.
// It decodes the enable, exception-level and mask fields for the gate.
module cop_status_reg
    import cop_timer_pkg::*;
#(
    parameter int           W       = 32,
    parameter logic [W-1:0] WMASK   = STATUS_WMASK,
    parameter logic [W-1:0] RST_VAL = STATUS_RST
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    status_q,
    output logic            ie,
    output logic            exl,
    output logic            erl,
    output logic [IM_W-1:0] im
);

    logic [W-1:0] state_q;

    // Storage: only the bits that hold state are loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_VAL & WMASK;
        end else if (we) begin
            state_q <= wdata & WMASK;
        end
    end

    // Field decode. The endian-reverse bit is forced to zero.
    always_comb begin
        status_q        = state_q & WMASK;
        status_q[ST_RE] = 1'b0;
        ie              = status_q[ST_IE];
        exl             = status_q[ST_EXL];
        erl             = status_q[ST_ERL];
        im              = status_q[ST_IM_LO +: IM_W];
    end

endmodule

// File: rtl/cop_irq_gate.sv
// Module: cop_irq_gate
// Builds the pending vector from the timer flag, the hardware lines
// (only the lines marked in HW_LIVE) and the software flags. Masks it
// and gates it with the enable bits. The request is combinational, so
// unmasking a source that is already pending raises it at once.
module cop_irq_gate #(
    parameter int                HW_N    = 5,
    parameter int                SW_N    = 2,
    parameter logic [HW_N-1:0]   HW_LIVE = 5'b00111,
    localparam int               PEND_W  = 1 + HW_N + SW_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [SW_N-1:0]   sw_wdata,
    input  logic [HW_N-1:0]   hw_irq,
    input  logic              tmr_pend,
    input  logic [PEND_W-1:0] im,
    input  logic              ie,
    input  logic              exl,
    input  logic              erl,
    output logic [PEND_W-1:0] pend_vec,
    output logic              irq_req
);

    logic [SW_N-1:0] sw_q;
    logic [HW_N-1:0] hw_seen;

    // Software flags: loaded by writes to the pending view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else if (sw_we) begin
            sw_q <= sw_wdata;
        end
    end

    // Hardware lines: unconnected lines tie off to zero.
    for (genvar i = 0; i < HW_N; i++) begin : g_hw
        if (HW_LIVE[i]) begin : g_live
            assign hw_seen[i] = hw_irq[i];
        end else begin : g_dead
            assign hw_seen[i] = 1'b0;
        end
    end

    // Pending vector: timer on top, hardware in the middle, software low.
    assign pend_vec = {tmr_pend, hw_seen, sw_q};

    // Request: any enabled source, with global enable and no exception level.
    assign irq_req = (|(pend_vec & im)) & ie & ~exl & ~erl;

endmodule

// File: rtl/cop_timer_intc.sv
// Module: cop_timer_intc (top)
// Coprocessor timer and interrupt-mask unit. Decodes the register bus,
// instances the counter/compare, status and gating slices, and muxes
// the read data. Reads are combinational and writes take effect on the clock edge.
module cop_timer_intc
    import cop_timer_pkg::*;
#(
    parameter logic [DATA_W-1:0] CMP_RST = 32'hFFFF_FFFF,
    parameter logic [HW_N-1:0]   HW_LIVE = 5'b00111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [HW_N-1:0]   hw_irq,
    output logic              irq_req
);

    localparam int PEND_W = 1 + HW_N + SW_N;

    reg_sel_e          sel;
    logic              cnt_we, cmp_we, st_we, pd_we;
    logic [DATA_W-1:0] count_q, cmp_q, status_q;
    logic              tmr_pend, ie, exl, erl;
    logic [IM_W-1:0]   im;
    logic [PEND_W-1:0] pend_vec;

    // Write decode: one strobe per register.
    always_comb begin
        sel    = reg_sel_e'(reg_sel);
        cnt_we = wr_en && (sel == SEL_COUNT);
        cmp_we = wr_en && (sel == SEL_CMP);
        st_we  = wr_en && (sel == SEL_STATUS);
        pd_we  = wr_en && (sel == SEL_PEND);
    end

    cop_count_cmp #(
        .W       (DATA_W),
        .CMP_RST (CMP_RST)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .cnt_we   (cnt_we),
        .cmp_we   (cmp_we),
        .wdata    (wr_data),
        .count_q  (count_q),
        .cmp_q    (cmp_q),
        .tmr_pend (tmr_pend)
    );

    cop_status_reg #(
        .W       (DATA_W),
        .WMASK   (STATUS_WMASK),
        .RST_VAL (STATUS_RST)
    ) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (st_we),
        .wdata    (wr_data),
        .status_q (status_q),
        .ie       (ie),
        .exl      (exl),
        .erl      (erl),
        .im       (im)
    );

    cop_irq_gate #(
        .HW_N    (HW_N),
        .SW_N    (SW_N),
        .HW_LIVE (HW_LIVE)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (pd_we),
        .sw_wdata (wr_data[SW_N-1:0]),
        .hw_irq   (hw_irq),
        .tmr_pend (tmr_pend),
        .im       (im),
        .ie       (ie),
        .exl      (exl),
        .erl      (erl),
        .pend_vec (pend_vec),
        .irq_req  (irq_req)
    );

    // Read mux: the selected register, with the pending view zero-extended.
    always_comb begin
        unique case (sel)
            SEL_COUNT:  rd_data = count_q;
            SEL_CMP:    rd_data = cmp_q;
            SEL_STATUS: rd_data = status_q;
            default:    rd_data = {{(DATA_W-PEND_W){1'b0}}, pend_vec};
        endcase
    end

endmodule

// File: rtl/cop_timer_intc_chk.sv
// Module: cop_timer_intc_chk
// Checker bound to cop_timer_intc. It relates the bus writes to the
// registers, the pending flags and the request over time.
module cop_timer_intc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        cnt_we,
    input logic        cmp_we,
    input logic [31:0] count_q,
    input logic [31:0] cmp_q,
    input logic        tmr_pend,
    input logic [31:0] status_q,
    input logic [7:0]  pend_vec,
    input logic        irq_req
);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && tick_en) |=> (count_q == $past(count_q) + 32'd1)); // R1

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == cmp_q && !cmp_we) |=> tmr_pend); // R2

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_pend && !cmp_we) |=> tmr_pend); // R2

    AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !tmr_pend); // R3

    AST_CMP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_we |=> $stable(cmp_q)); // R4

    AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & 32'hEE00_0000) == 32'h0); // R6

    AST_DEAD_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vec[6:5] == 2'b00); // R8

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (status_q[0] && !status_q[1] && !status_q[2])); // R9

    AST_REQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(pend_vec & status_q[15:8])) && status_q[0] && !status_q[1]
         && !status_q[2]) |-> irq_req); // R9

endmodule

bind cop_timer_intc cop_timer_intc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cnt_we   (cnt_we),
    .cmp_we   (cmp_we),
    .count_q  (count_q),
    .cmp_q    (cmp_q),
    .tmr_pend (tmr_pend),
    .status_q (status_q),
    .pend_vec (pend_vec),
    .irq_req  (irq_req)
);

// File: tb/cop_timer_intc_test.sv
// Bench for cop_timer_intc: a vector table of register write/readback
// pairs, followed by directed tests for reset, timer and gating corners.
module cop_timer_intc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  hw_irq = '0;
    logic        irq_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cop_timer_intc uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .hw_irq  (hw_irq),
        .irq_req (irq_req)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    // Write a register, then expect this value when it is read back.
    localparam vec_t VEC [8] = '{
        '{2'd2, 32'hFFFF_FFFF, 32'h11FF_FFFF},
        '{2'd2, 32'h0200_0000, 32'h0000_0000},
        '{2'd2, 32'h1234_5678, 32'h1034_5678},
        '{2'd2, 32'hA5A5_A5A5, 32'h01A5_A5A5},
        '{2'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{2'd3, 32'hFFFF_FFFF, 32'h0000_0003},
        '{2'd3, 32'h0000_0000, 32'h0000_0000},
        '{2'd0, 32'h0000_1000, 32'h0000_1000}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        reg_sel = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #0.5;
        data = rd_data;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state.
        rd(2'd0, v); check("R10 count", v, 32'h0);
        rd(2'd2, v); check("R10 status", v, 32'h4);
        rd(2'd3, v); check("R10 pending", v, 32'h0);
        check("R10 irq", {31'h0, irq_req}, 32'h0);

        // R5 R6 R4 R7 R1: vector table.
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i].sel, VEC[i].wd);
            rd(VEC[i].sel, v);
            check("R5/R6/R4/R7/R1 vector", v, VEC[i].exp);
        end

        // R1: counting, wrapping, write over tick.
        wr(2'd0, 32'd5);
        tick_en = 1'b1;
        repeat (10) @(negedge clk);
        tick_en = 1'b0;
        rd(2'd0, v); check("R1 count", v, 32'd15);
        wr(2'd0, 32'hFFFF_FFFF);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        rd(2'd0, v); check("R1 wrap", v, 32'h0);
        tick_en = 1'b1;
        wr(2'd0, 32'h100);
        tick_en = 1'b0;
        rd(2'd0, v); check("R1 write beats tick", v, 32'h100);

        // R2: match latch with the mask clear.
        wr(2'd2, 32'h0000_0001);
        wr(2'd1, 32'd20);
        wr(2'd0, 32'd10);
        rd(2'd3, v); check("R2 no early pend", v, 32'h0);
        tick_en = 1'b1;
        repeat (10) @(negedge clk);
        tick_en = 1'b0;
        rd(2'd0, v); check("R2 count at match", v, 32'd20);
        rd(2'd3, v); check("R2 pend one edge later", v, 32'h0);
        @(negedge clk);
        rd(2'd3, v); check("R2 pend set", v, 32'h80);
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd(2'd3, v); check("R2 pend held", v, 32'h80);
        check("R9 masked", {31'h0, irq_req}, 32'h0);

        // R9: late enable and exception-level gating.
        wr(2'd2, 32'h0000_8001);
        check("R9 late unmask", {31'h0, irq_req}, 32'h1);
        wr(2'd2, 32'h0000_8003);
        check("R9 EXL blocks", {31'h0, irq_req}, 32'h0);
        wr(2'd2, 32'h0000_8005);
        check("R9 ERL blocks", {31'h0, irq_req}, 32'h0);
        wr(2'd2, 32'h0000_8000);
        check("R9 IE clear", {31'h0, irq_req}, 32'h0);
        wr(2'd2, 32'h0000_8001);
        check("R9 re-enable", {31'h0, irq_req}, 32'h1);

        // R3: compare write clears, and wins over a same-cycle match.
        wr(2'd0, 32'd25);
        wr(2'd1, 32'd25);
        rd(2'd3, v); check("R3 write clears", v, 32'h0);
        @(negedge clk);
        rd(2'd3, v); check("R3 rematch", v, 32'h80);
        wr(2'd1, 32'd25);
        rd(2'd3, v); check("R3 write beats match", v, 32'h0);
        wr(2'd1, 32'h7);
        repeat (3) @(negedge clk);
        rd(2'd3, v); check("R3 stays clear", v, 32'h0);
        check("R3 irq clear", {31'h0, irq_req}, 32'h0);
        rd(2'd1, v); check("R4 compare readback", v, 32'h7);

        // R8 R7: hardware lines, dead lines never seen.
        hw_irq = 5'b11111;
        wr(2'd2, 32'h0000_6001);
        rd(2'd3, v); check("R8 dead lines zero", v, 32'h1C);
        check("R8 dead lines no irq", {31'h0, irq_req}, 32'h0);
        wr(2'd2, 32'h0000_0401);
        check("R7 hw line 0", {31'h0, irq_req}, 32'h1);
        hw_irq = 5'b00000;
        #0.5;
        check("R7 hw line drop", {31'h0, irq_req}, 32'h0);

        // R7: software flags through the pending view.
        wr(2'd2, 32'h0000_0201);
        wr(2'd3, 32'hFFFF_FF02);
        rd(2'd3, v); check("R7 sw set", v, 32'h2);
        check("R7 sw irq", {31'h0, irq_req}, 32'h1);
        wr(2'd3, 32'h0);
        check("R7 sw clear", {31'h0, irq_req}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule